// File: doc/BRIEF.md
# Packed Halfword Cross-Lane Add/Subtract Unit

This unit treats each 32-bit operand as two 16-bit lanes and combines them across lanes. The upper half of operand A is paired with the lower half of operand B, and the lower half of A is paired with the upper half of B. One pairing is added and the other is subtracted, and the 3-bit operation select picks which. The same select also chooses between signed and unsigned lanes, and between a plain wrapping result and a halved result.

The arithmetic is combinational, and its outputs are captured in a register one clock after an accepted request. Plain operations also return four greater-or-equal flags. These come as two duplicated pairs, one pair per lane. The host pipeline latches the flags when the flag-valid strobe is high. Halving operations never raise that strobe.

Top module: `xlane_addsub_unit`

## Requirements
- R1: With opSel[0]=1 (add-sub), the result upper half is A[31:16]+B[15:0] and the lower half is A[15:0]-B[31:16].
- R2: With opSel[0]=0 (sub-add), the result upper half is A[31:16]-B[15:0] and the lower half is A[15:0]+B[31:16].
- R3: opSel[1]=1 sign-extends every 16-bit half to 17 bits before the arithmetic; opSel[1]=0 zero-extends it.
- R4: opSel[2]=1 (halving) outputs bits [16:1] of each 17-bit lane result; opSel[2]=0 outputs bits [15:0], wrapping with no saturation.
- R5: geFlags[3] and geFlags[2] both carry the upper-lane flag; geFlags[1] and geFlags[0] both carry the lower-lane flag.
- R6: A sum lane's flag is the carry out (sum >= 0x10000) when unsigned, and (sum >= 0) when signed.
- R7: A difference lane's flag is (extended difference >= 0) in both modes, meaning no borrow when unsigned.
- R8: A halving operation leaves geValid low and loads geFlags with 4'b0000.
- R9: An operation accepted with inValid high appears on result, geFlags and resValid after exactly one rising edge. geValid rises after that edge only for non-halving operations. While inValid is low, result and geFlags hold and both valids are low.
- R10: A synchronous active-high rst clears result, geFlags, resValid and geValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and select are valid this cycle |
| opSel | input | 3 | [0] add-sub/sub-add, [1] signed, [2] halving |
| opA | input | 32 | First packed operand |
| opB | input | 32 | Second packed operand |
| resValid | output | 1 | result holds a new value |
| result | output | 32 | Packed result |
| geValid | output | 1 | geFlags holds new flags from a non-halving operation |
| geFlags | output | 4 | Duplicated per-lane greater-or-equal flags |

## Verification
The assertions assume that rst is sampled synchronously. They also assume that opSel is known whenever inValid is high. All eight select encodings are legal, so no select needs to be excluded. The stimulus changes inputs only on falling edges and keeps opSel defined at all times. It draws operands from lane extremes (0x0000, 0x0001, 0x7FFF, 0x8000, 0xFFFF) as well as random values. It also inserts idle cycles and a reset in the middle of traffic, so the hold and clear paths are exercised.

// File: rtl/xlane_pkg.sv
package xlane_pkg;
  localparam int OP_W        = 3;
  localparam int OP_ADDSUB   = 0;
  localparam int OP_SIGNED   = 1;
  localparam int OP_HALVING  = 2;

  typedef struct packed {
    logic load;
    logic hiIsSum;
    logic signedLanes;
    logic halving;
    logic geLoad;
  } xlaneStrobe_t;
endpackage

// File: rtl/xlane_ctrl.sv
module xlane_ctrl
  import xlane_pkg::*;
(
  input  logic            inValid,
  input  logic [OP_W-1:0] opSel,
  output xlaneStrobe_t    stb
);
  always_comb begin
    stb.load        = inValid;
    stb.hiIsSum     = opSel[OP_ADDSUB];
    stb.signedLanes = opSel[OP_SIGNED];
    stb.halving     = opSel[OP_HALVING];
    stb.geLoad      = inValid & ~opSel[OP_HALVING];
  end
endmodule

// File: rtl/xlane_dp.sv
module xlane_dp
  import xlane_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  xlaneStrobe_t          stb,
  input  logic [2*LANE_W-1:0]   opA,
  input  logic [2*LANE_W-1:0]   opB,
  output logic                  resValid,
  output logic [2*LANE_W-1:0]   result,
  output logic                  geValid,
  output logic [3:0]            geFlags
);
  localparam int NUM_LANES = 2;
  localparam int EXT_W     = LANE_W + 1;
  localparam int DATA_W    = NUM_LANES * LANE_W;
  localparam int GE_W      = 2 * NUM_LANES;

  logic [DATA_W-1:0] resNext;
  logic [GE_W-1:0]   geNext;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int OTHER = NUM_LANES - 1 - g;
    logic [LANE_W-1:0] aLane, bLane;
    logic [EXT_W-1:0]  aExt, bExt, laneRes;
    logic              isSum, laneGe;

    assign aLane   = opA[g*LANE_W +: LANE_W];
    assign bLane   = opB[OTHER*LANE_W +: LANE_W];
    assign aExt    = {stb.signedLanes & aLane[LANE_W-1], aLane};
    assign bExt    = {stb.signedLanes & bLane[LANE_W-1], bLane};
    assign isSum   = (g == NUM_LANES - 1) ? stb.hiIsSum : ~stb.hiIsSum;
    assign laneRes = isSum ? (aExt + bExt) : (aExt - bExt);
    assign laneGe  = (isSum & ~stb.signedLanes) ? laneRes[LANE_W] : ~laneRes[LANE_W];
    assign resNext[g*LANE_W +: LANE_W] = stb.halving ? laneRes[LANE_W:1]
                                                     : laneRes[LANE_W-1:0];
    assign geNext[2*g +: 2] = {2{laneGe & ~stb.halving}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      geValid  <= 1'b0;
      result   <= '0;
      geFlags  <= '0;
    end else begin
      resValid <= stb.load;
      geValid  <= stb.geLoad;
      if (stb.load) begin
        result  <= resNext;
        geFlags <= geNext;
      end
    end
  end

  // R5: flags always come as equal pairs per lane
  p_ge_pairs_r5: assert property (@(posedge clk) disable iff (rst)
    (geFlags[3] == geFlags[2]) && (geFlags[1] == geFlags[0]));

  // R8: a halving load leaves no flags behind
  p_halving_noge_r8: assert property (@(posedge clk) disable iff (rst)
    (stb.load && stb.halving) |=> (!geValid && geFlags == '0));

  // R9: idle cycles hold the registered outputs
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !stb.load |=> ($stable(result) && $stable(geFlags) && !resValid && !geValid));
endmodule

// File: rtl/xlane_addsub_unit.sv
module xlane_addsub_unit
  import xlane_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [OP_W-1:0]     opSel,
  input  logic [2*LANE_W-1:0] opA,
  input  logic [2*LANE_W-1:0] opB,
  output logic                resValid,
  output logic [2*LANE_W-1:0] result,
  output logic                geValid,
  output logic [3:0]          geFlags
);
  xlaneStrobe_t stb;

  xlane_ctrl u_ctrl (
    .inValid (inValid),
    .opSel   (opSel),
    .stb     (stb)
  );

  xlane_dp #(.LANE_W(LANE_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .opA      (opA),
    .opB      (opB),
    .resValid (resValid),
    .result   (result),
    .geValid  (geValid),
    .geFlags  (geFlags)
  );

  // R9: one-cycle latency of the valid, flag strobe only for plain ops
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (resValid && (geValid == !$past(opSel[OP_HALVING]))));

  // R10: reset clears both strobes and the result
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!resValid && !geValid && result == '0 && geFlags == '0));
endmodule

// File: tb/sim_xlane_addsub_unit.sv
module sim_xlane_addsub_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = 3'b000;
  logic [31:0] opA = '0, opB = '0;
  logic        resValid, geValid;
  logic [31:0] result;
  logic [3:0]  geFlags;

  int checks = 0;
  int fails  = 0;

  logic        expResValid = 1'b0, expGeValid = 1'b0;
  logic [31:0] expResult = '0;
  logic [3:0]  expGe = '0;
  logic [2:0]  lastOp = 3'b000;
  logic        lastRst = 1'b1;

  always #10 clk = ~clk;

  xlane_addsub_unit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .resValid(resValid), .result(result),
    .geValid(geValid), .geFlags(geFlags)
  );

  task automatic report(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of one operation
  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic [3:0] ge);
    int ah, al, bh, bl, hi, lo;
    bit hiGe, loGe;
    if (op[1]) begin
      ah = int'($signed(a[31:16])); al = int'($signed(a[15:0]));
      bh = int'($signed(b[31:16])); bl = int'($signed(b[15:0]));
    end else begin
      ah = int'(a[31:16]); al = int'(a[15:0]);
      bh = int'(b[31:16]); bl = int'(b[15:0]);
    end
    if (op[0]) begin
      hi = ah + bl; lo = al - bh;
      hiGe = op[1] ? (hi >= 0) : (hi >= 65536);
      loGe = (lo >= 0);
    end else begin
      hi = ah - bl; lo = al + bh;
      hiGe = (hi >= 0);
      loGe = op[1] ? (lo >= 0) : (lo >= 65536);
    end
    if (op[2]) begin
      r  = {16'((hi >>> 1) & 32'hFFFF), 16'((lo >>> 1) & 32'hFFFF)};
      ge = 4'b0000;
    end else begin
      r  = {16'(hi & 32'hFFFF), 16'(lo & 32'hFFFF)};
      ge = {hiGe, hiGe, loGe, loGe};
    end
  endtask

  // compare at the falling edge, then drive the next cycle's inputs
  task automatic step(input logic r, input logic v, input logic [2:0] op,
                      input logic [31:0] a, input logic [31:0] b);
    logic [31:0] mr;
    logic [3:0]  mg;
    @(negedge clk);
    if (lastRst) begin
      report("R10 resValid", {31'b0, resValid}, 32'd0);
      report("R10 geValid", {31'b0, geValid}, 32'd0);
      report("R10 result", result, 32'd0);
      report("R10 geFlags", {28'b0, geFlags}, 32'd0);
    end else begin
      report("R9 resValid", {31'b0, resValid}, {31'b0, expResValid});
      report(lastOp[2] ? "R8 geValid" : "R9 geValid", {31'b0, geValid}, {31'b0, expGeValid});
      report(lastOp[2] ? "R4 result" : (lastOp[0] ? "R1 result" : "R2 result"), result, expResult);
      report(lastOp[2] ? "R8 geFlags" : "R5 geFlags", {28'b0, geFlags}, {28'b0, expGe});
    end
    rst = r; inValid = v; opSel = op; opA = a; opB = b;
    lastRst = r;
    if (r) begin
      expResValid = 1'b0; expGeValid = 1'b0; expResult = '0; expGe = '0;
    end else begin
      expResValid = v;
      expGeValid  = v & ~op[2];
      if (v) begin
        model(op, a, b, mr, mg);
        expResult = mr; expGe = mg; lastOp = op;
      end
    end
  endtask

  task automatic directed(input string tag, input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] er, input logic [3:0] eg);
    step(1'b0, 1'b1, op, a, b);
    @(posedge clk);
    #5;
    report(tag, result, er);
    report(tag, {28'b0, geFlags}, {28'b0, eg});
  endtask

  function automatic logic [15:0] pick();
    case ($urandom_range(0, 5))
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (3) step(1'b1, 1'b0, 3'b000, '0, '0);
    step(1'b0, 1'b0, 3'b000, '0, '0);   // R10 reset state observed here
    // R6 unsigned sum carry, R7 difference borrow (add-sub, unsigned)
    directed("R6 unsigned carry", 3'b001, 32'hFFFF_0001, 32'h0002_0001, 32'h0000_FFFF, 4'b1100);
    // R3 unsigned halving vs signed halving on the same operands
    directed("R3 zero-extend", 3'b101, 32'hFFFF_0000, 32'h0000_0001, 32'h8000_0000, 4'b0000);
    directed("R3 sign-extend", 3'b111, 32'hFFFF_0000, 32'h0000_0001, 32'h0000_0000, 4'b0000);
    // R7 difference borrow in sub-add unsigned
    directed("R7 unsigned borrow", 3'b000, 32'h0005_0003, 32'h0004_0006, 32'hFFFF_0007, 4'b0000);
    // R6 signed negative sum, R7 signed zero difference
    directed("R6 R7 signed", 3'b010, 32'h0005_8000, 32'h8000_0005, 32'h0000_0000, 4'b1100);
    // R4 halving of a wrapping sum
    directed("R4 halving", 3'b100, 32'h0001_FFFF, 32'h0001_0002, 32'hFFFF_8000, 4'b0000);
    for (int i = 0; i < 600; i++) begin
      logic r;
      r = (i == 300);
      step(r, ($urandom_range(0, 3) != 0), 3'($urandom), {pick(), pick()}, {pick(), pick()});
    end
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 3'b000, '0, '0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule